// File: doc/BRIEF.md
# FIFO-Buffered SPI Master With Byte Counters

This block is a serial peripheral interface master run from a 32-bit register port. Software sets a serial clock divider, gates the serial clock on, loads separate transmit and receive byte counts, fills a 16-byte transmit queue and then switches on programmed-I/O mode. The shift engine sends one 8-bit word for every counted byte, most significant bit first or least significant bit first. While the transmit count is nonzero it takes each word from the transmit queue. Once that count is exhausted it shifts zeros for the receive side. Each word received while the receive count is nonzero lands in a 16-byte receive queue, and software drains that queue by reading.

Three sticky events can raise a level interrupt, each through its own enable: a received word stored, the transmit queue drained by the engine, and the end of the transfer. Software clears an event by writing a one to its bit. The serial clock idles low (mode 0). The chip select is active low and stays asserted while a counted transfer is armed or running. It is released one serial clock period after the last bit.

The register port carries requests on a valid/ready channel. Read data returns on a valid/ready response channel. A write and a read are both accepted in any cycle where `req_ready` is high. `req_ready` is low only while a read response is waiting and `rsp_ready` is low. A waiting response holds its data unchanged until it is taken. Writes produce no response.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sclk` is 0, `irq` is 0, the divider reads 2 and the level register at 0x10C reads 0.
- R2: The level register at 0x10C reports the transmit queue occupancy in bits 15:8 and the receive queue occupancy in bits 31:24. Each queue holds 16 bytes. A write to TX data (0x10) while the transmit queue is full is dropped and leaves its contents and occupancy unchanged.
- R3: A read of RX data (0x20) while the receive queue is empty returns 0 and leaves the occupancy unchanged.
- R4: The divider at 0x30 stores the written value clamped to the range 2..2047 and reads back the stored value. One serial clock period lasts that many system clocks.
- R5: The serial clock runs only while the clock-control register at 0x00 holds 0xD. With any other value no SCLK edge occurs and the transfer waits.
- R6: A write to config (0x04) takes effect only when bit 18 of the written data is 1. The stored fields are bit 5 (programmed-I/O enable), bit 7 (receive interrupt enable), bit 8 (transmit-empty interrupt enable), bit 13 (LSB-first) and bit 21 (completion interrupt enable). These read back at the same positions, and bit 18 reads 0.
- R7: With bit 13 clear each word is shifted MSB first, and with it set LSB first. MOSI changes only while SCLK is low. MISO is sampled on the rising SCLK edge and assembled in the same order.
- R8: The TX count (0x4C) and the RX count (0x34) each decrement once per word shifted while they are nonzero. The engine shifts max(TX, RX) words, sending 0x00 once the TX count is zero, and stores only the first RX-count received words.
- R9: Status (0x08) bit 0 sets when a received word is stored, bit 1 sets when the engine takes the last word out of the transmit queue, and bit 22 sets when the transfer ends. Writing a 1 to a bit clears it.
- R10: `irq` is high exactly while some status bit is set together with its enable (bit 0 with bit 7, bit 1 with bit 8, bit 22 with bit 21). It stays high until software clears the status bit or the enable.
- R11: `spi_cs_n` is low while programmed-I/O is enabled and a count is nonzero, or while the engine is busy. It rises one serial clock period after the last bit.
- R12: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response taken |
| rsp_rdata | output | 32 | Read response data |
| irq | output | 1 | Level interrupt |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The assertions assume that software does not rewrite a count, the divider or the bit order while words are shifting, and that it never lets the receive queue overflow. The stimulus keeps to this. Every transfer is set up with programmed-I/O off, no transfer asks for more than 16 received words, and the receive queue is drained before the next one starts. MISO is looped back from MOSI, so the received words can be predicted from the transmitted ones. The response channel is stalled only by the bench's own `rsp_ready`.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFF_CLKCTL = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_CFG    = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_TXD    = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_RXD    = 12'h020;
  localparam logic [ADDR_W-1:0] OFF_DIV    = 12'h030;
  localparam logic [ADDR_W-1:0] OFF_RXCNT  = 12'h034;
  localparam logic [ADDR_W-1:0] OFF_TXCNT  = 12'h04C;
  localparam logic [ADDR_W-1:0] OFF_LEVEL  = 12'h10C;

  localparam int CFG_PIO     = 5;
  localparam int CFG_IE_RX   = 7;
  localparam int CFG_IE_TXE  = 8;
  localparam int CFG_LSB     = 13;
  localparam int CFG_COMMIT  = 18;
  localparam int CFG_IE_DONE = 21;

  localparam int ST_RX   = 0;
  localparam int ST_TXE  = 1;
  localparam int ST_DONE = 22;

  localparam int LVL_TX_LSB = 8;
  localparam int LVL_RX_LSB = 24;

  localparam logic [3:0] CLK_RUN_CODE = 4'hD;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SHIFT = 2'd1,
    ENG_TAIL  = 2'd2
  } eng_state_t;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [W-1:0]       push_data,
  input  logic               pop,
  output logic [W-1:0]       head,
  output logic               full,
  output logic               empty,
  output logic [$clog2(DEPTH):0] level
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = PTR_W + 1;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full    = (level == LVL_W'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_fifo_pkg::*;
#(
  parameter int DIV_W   = 11,
  parameter int DIV_MIN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_on,
  input  logic             start_en,
  input  logic [DIV_W-1:0] div,
  input  logic             lsb_first,
  input  logic             tx_pending,
  input  logic             rx_pending,
  input  logic             tx_have,
  input  logic             rx_room,
  input  logic [7:0]       tx_byte,
  output logic             tx_take,
  output logic             byte_end,
  output logic             end_tx,
  output logic             end_rx,
  output logic [7:0]       rx_byte,
  output logic             tail_end,
  output logic             busy,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso
);
  eng_state_t       state;
  logic [DIV_W-1:0] tick, div_q, half, last_tick;
  logic [2:0]       bit_idx;
  logic [7:0]       sh_out, sh_in, in_next;
  logic             with_tx, with_rx, lsb_q, ran;
  logic             can_start, go_tail, sample, bit_end;

  assign half      = div_q >> 1;
  assign last_tick = div_q - DIV_W'(1);

  always_comb begin
    can_start = (state == ENG_IDLE) && clk_on && start_en &&
                (tx_pending || rx_pending) &&
                (!tx_pending || tx_have) && (!rx_pending || rx_room);
    go_tail   = (state == ENG_IDLE) && clk_on && ran && !tx_pending && !rx_pending;
    sample    = (state == ENG_SHIFT) && clk_on && (tick == half);
    bit_end   = (state == ENG_SHIFT) && clk_on && (tick == last_tick);
    if (sample) in_next = lsb_q ? {miso, sh_in[7:1]} : {sh_in[6:0], miso};
    else        in_next = sh_in;
  end

  assign tx_take  = can_start && tx_pending;
  assign byte_end = bit_end && (bit_idx == 3'd7);
  assign end_tx   = with_tx;
  assign end_rx   = with_rx;
  assign rx_byte  = in_next;
  assign tail_end = (state == ENG_TAIL) && clk_on && (tick == last_tick);
  assign busy     = (state != ENG_IDLE) || ran;
  assign sclk     = (state == ENG_SHIFT) && (tick >= half);
  assign mosi     = (state == ENG_SHIFT) && (lsb_q ? sh_out[0] : sh_out[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ENG_IDLE;
      tick    <= '0;
      div_q   <= DIV_W'(DIV_MIN);
      bit_idx <= '0;
      sh_out  <= '0;
      sh_in   <= '0;
      with_tx <= 1'b0;
      with_rx <= 1'b0;
      lsb_q   <= 1'b0;
      ran     <= 1'b0;
    end else begin
      case (state)
        ENG_IDLE: begin
          if (can_start) begin
            state   <= ENG_SHIFT;
            tick    <= '0;
            bit_idx <= '0;
            div_q   <= div;
            lsb_q   <= lsb_first;
            sh_out  <= tx_pending ? tx_byte : 8'h00;
            sh_in   <= '0;
            with_tx <= tx_pending;
            with_rx <= rx_pending;
            ran     <= 1'b1;
          end else if (go_tail) begin
            state <= ENG_TAIL;
            tick  <= '0;
          end
        end
        ENG_SHIFT: begin
          if (clk_on) begin
            sh_in <= in_next;
            if (bit_end) begin
              tick <= '0;
              if (bit_idx == 3'd7) begin
                state <= ENG_IDLE;
              end else begin
                bit_idx <= bit_idx + 3'd1;
                sh_out  <= lsb_q ? (sh_out >> 1) : (sh_out << 1);
              end
            end else begin
              tick <= tick + DIV_W'(1);
            end
          end
        end
        ENG_TAIL: begin
          if (clk_on) begin
            if (tail_end) begin
              state <= ENG_IDLE;
              ran   <= 1'b0;
              tick  <= '0;
            end else begin
              tick <= tick + DIV_W'(1);
            end
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = 16,
  parameter int DIV_W      = 11,
  parameter int DIV_MIN    = 2,
  parameter int DIV_MAX    = 2047
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              irq,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;

  logic [3:0]       clkctl;
  logic [DIV_W-1:0] div_r;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic             pio_en, ie_rx, ie_txe, ie_done, lsb_first;
  logic             st_rx, st_txe, st_done;
  logic             wr_acc, rd_acc, clk_on;
  logic             tx_pending, rx_pending;

  logic             tx_push, tx_pop, tx_full, tx_empty;
  logic [7:0]       tx_head;
  logic [LVL_W-1:0] tx_level;
  logic             rx_push, rx_pop, rx_full, rx_empty;
  logic [7:0]       rx_head, rx_byte;
  logic [LVL_W-1:0] rx_level;

  logic             byte_end, end_tx, end_rx, tail_end, busy;
  logic [31:0]      rd_mux;

  function automatic logic [DIV_W-1:0] clamp_div(input logic [31:0] v);
    if (v < 32'(DIV_MIN))      return DIV_W'(DIV_MIN);
    else if (v > 32'(DIV_MAX)) return DIV_W'(DIV_MAX);
    else                       return v[DIV_W-1:0];
  endfunction

  assign req_ready  = !rsp_valid || rsp_ready;
  assign wr_acc     = req_valid && req_ready && req_write;
  assign rd_acc     = req_valid && req_ready && !req_write;
  assign clk_on     = (clkctl == CLK_RUN_CODE);
  assign tx_pending = (tx_cnt != '0);
  assign rx_pending = (rx_cnt != '0);

  assign tx_push = wr_acc && (req_addr == OFF_TXD);
  assign rx_pop  = rd_acc && (req_addr == OFF_RXD);
  assign rx_push = byte_end && end_rx;

  spi_byte_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push), .push_data(req_wdata[7:0]),
    .pop(tx_pop), .head(tx_head),
    .full(tx_full), .empty(tx_empty), .level(tx_level)
  );

  spi_byte_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .push_data(rx_byte),
    .pop(rx_pop), .head(rx_head),
    .full(rx_full), .empty(rx_empty), .level(rx_level)
  );

  spi_shift_engine #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .clk_on(clk_on), .start_en(pio_en),
    .div(div_r), .lsb_first(lsb_first),
    .tx_pending(tx_pending), .rx_pending(rx_pending),
    .tx_have(!tx_empty), .rx_room(!rx_full),
    .tx_byte(tx_head), .tx_take(tx_pop),
    .byte_end(byte_end), .end_tx(end_tx), .end_rx(end_rx),
    .rx_byte(rx_byte), .tail_end(tail_end), .busy(busy),
    .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso)
  );

  // Register writes, counters and sticky events
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkctl    <= '0;
      div_r     <= DIV_W'(DIV_MIN);
      tx_cnt    <= '0;
      rx_cnt    <= '0;
      pio_en    <= 1'b0;
      ie_rx     <= 1'b0;
      ie_txe    <= 1'b0;
      ie_done   <= 1'b0;
      lsb_first <= 1'b0;
      st_rx     <= 1'b0;
      st_txe    <= 1'b0;
      st_done   <= 1'b0;
    end else begin
      if (wr_acc && req_addr == OFF_CLKCTL) clkctl <= req_wdata[3:0];
      if (wr_acc && req_addr == OFF_DIV)    div_r  <= clamp_div(req_wdata);
      if (wr_acc && req_addr == OFF_CFG && req_wdata[CFG_COMMIT]) begin
        pio_en    <= req_wdata[CFG_PIO];
        ie_rx     <= req_wdata[CFG_IE_RX];
        ie_txe    <= req_wdata[CFG_IE_TXE];
        ie_done   <= req_wdata[CFG_IE_DONE];
        lsb_first <= req_wdata[CFG_LSB];
      end

      if (wr_acc && req_addr == OFF_TXCNT)    tx_cnt <= req_wdata[CNT_W-1:0];
      else if (byte_end && end_tx && tx_pending) tx_cnt <= tx_cnt - CNT_W'(1);
      if (wr_acc && req_addr == OFF_RXCNT)    rx_cnt <= req_wdata[CNT_W-1:0];
      else if (byte_end && end_rx && rx_pending) rx_cnt <= rx_cnt - CNT_W'(1);

      if (rx_push) st_rx <= 1'b1;
      else if (wr_acc && req_addr == OFF_STAT && req_wdata[ST_RX]) st_rx <= 1'b0;
      if (tx_pop && tx_level == LVL_W'(1) && !tx_push) st_txe <= 1'b1;
      else if (wr_acc && req_addr == OFF_STAT && req_wdata[ST_TXE]) st_txe <= 1'b0;
      if (tail_end) st_done <= 1'b1;
      else if (wr_acc && req_addr == OFF_STAT && req_wdata[ST_DONE]) st_done <= 1'b0;
    end
  end

  // Read data selection
  always_comb begin
    rd_mux = '0;
    case (req_addr)
      OFF_CLKCTL: rd_mux[3:0] = clkctl;
      OFF_CFG: begin
        rd_mux[CFG_PIO]     = pio_en;
        rd_mux[CFG_IE_RX]   = ie_rx;
        rd_mux[CFG_IE_TXE]  = ie_txe;
        rd_mux[CFG_IE_DONE] = ie_done;
        rd_mux[CFG_LSB]     = lsb_first;
      end
      OFF_STAT: begin
        rd_mux[ST_RX]   = st_rx;
        rd_mux[ST_TXE]  = st_txe;
        rd_mux[ST_DONE] = st_done;
      end
      OFF_RXD:   rd_mux[7:0] = rx_empty ? 8'h00 : rx_head;
      OFF_DIV:   rd_mux[DIV_W-1:0] = div_r;
      OFF_RXCNT: rd_mux[CNT_W-1:0] = rx_cnt;
      OFF_TXCNT: rd_mux[CNT_W-1:0] = tx_cnt;
      OFF_LEVEL: begin
        rd_mux[LVL_TX_LSB +: 8] = 8'(tx_level);
        rd_mux[LVL_RX_LSB +: 8] = 8'(rx_level);
      end
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd_acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign irq      = (st_rx && ie_rx) || (st_txe && ie_txe) || (st_done && ie_done);
  assign spi_cs_n = !(busy || (pio_en && (tx_pending || rx_pending)));
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
  parameter int LVL_W = 5,
  parameter int DEPTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [31:0]      rsp_rdata,
  input logic             irq,
  input logic             spi_sclk,
  input logic             spi_mosi,
  input logic             spi_cs_n,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] rx_level
);
  // R12: a stalled response keeps its data
  a_r12_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  // R12: no request taken while a response is stalled
  a_r12_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  // R11: serial clock pulses only inside chip select
  a_r11_sclk_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> !spi_cs_n);

  // R11: chip select is released only after SCLK has been low
  a_r11_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> !spi_sclk && $past(!spi_sclk));

  // R7: data out does not move while SCLK is high
  a_r7_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk && $past(spi_sclk) |-> $stable(spi_mosi));

  // R2: queues never exceed their capacity
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= LVL_W'(DEPTH) && rx_level <= LVL_W'(DEPTH));

  // R10: interrupt holds until software writes a register
  a_r10_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !(req_valid && req_ready && req_write) |=> irq);
endmodule

bind spi_fifo_master spi_fifo_master_chk #(
  .LVL_W($clog2(FIFO_DEPTH) + 1),
  .DEPTH(FIFO_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .irq(irq), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
  .tx_level(tx_level), .rx_level(rx_level)
);

// File: tb/test_spi_fifo_master.sv
module test_spi_fifo_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, irq, spi_sclk, spi_mosi, spi_cs_n, spi_miso;
  logic [31:0] rsp_rdata;

  int checks = 0, errors = 0, cyc = 0;
  int edge_n = 0;
  int edge_t [512];
  logic bits [512];

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;
  assign spi_miso = spi_mosi;

  always @(posedge spi_sclk) begin
    if (edge_n < 512) begin
      bits[edge_n]   = spi_mosi;
      edge_t[edge_n] = cyc;
    end
    edge_n++;
  end

  spi_fifo_master i_spi_fifo_master (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .irq(irq), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  // {tx count, rx count, lsb-first, divider, seed}
  localparam logic [31:0] VECS [6] = '{
    {8'd4,  8'd4,  1'b0, 11'd2, 4'd1},
    {8'd3,  8'd3,  1'b1, 11'd5, 4'd2},
    {8'd2,  8'd5,  1'b0, 11'd4, 4'd3},
    {8'd6,  8'd2,  1'b1, 11'd3, 4'd4},
    {8'd0,  8'd3,  1'b0, 11'd2, 4'd5},
    {8'd16, 8'd16, 1'b0, 11'd2, 4'd6}
  };

  localparam logic [31:0] COMMIT = 32'h0004_0000;
  localparam logic [31:0] PIO    = 32'h0000_0020;
  localparam logic [31:0] LSB    = 32'h0000_2000;
  localparam logic [31:0] IEDONE = 32'h0020_0000;
  localparam logic [31:0] DONE   = 32'h0040_0000;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int t = 0; t < 4000; t++) begin
      bus_rd(12'h008, s);
      if (s[22]) return;
    end
  endtask

  function automatic logic [7:0] vbyte(input int seed, input int i);
    return 8'(seed * 16 + i * 29 + 3);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 cs_n", {31'd0, spi_cs_n}, 32'd1);
    chk("R1 sclk", {31'd0, spi_sclk}, 32'd0);
    chk("R1 irq",  {31'd0, irq}, 32'd0);
    bus_rd(12'h030, d); chk("R1 divider", d, 32'd2);
    bus_rd(12'h10C, d); chk("R1 level", d, 32'd0);

    // Table of transfers, MISO looped back from MOSI
    foreach (VECS[v]) begin
      int ntx, nrx, dv, seed, nmax;
      logic lsb;
      ntx = int'(VECS[v][31:24]); nrx = int'(VECS[v][23:16]);
      lsb = VECS[v][15]; dv = int'(VECS[v][14:4]); seed = int'(VECS[v][3:0]);
      nmax = (ntx > nrx) ? ntx : nrx;
      bus_wr(12'h000, 32'h0);
      bus_wr(12'h030, 32'(dv));
      bus_wr(12'h000, 32'hD);
      bus_wr(12'h04C, 32'(ntx));
      bus_wr(12'h034, 32'(nrx));
      for (int i = 0; i < ntx; i++) bus_wr(12'h010, 32'(vbyte(seed, i)));
      edge_n = 0;
      bus_wr(12'h004, COMMIT | PIO | (lsb ? LSB : 32'h0));
      wait_done();
      chk("R8 sclk edge count", 32'(edge_n), 32'(8 * nmax));
      chk("R4 sclk period", 32'(edge_t[1] - edge_t[0]), 32'(dv));
      for (int k = 0; k < 8 * nmax; k++) begin
        logic [7:0] b;
        logic e;
        b = (k / 8 < ntx) ? vbyte(seed, k / 8) : 8'h00;
        e = lsb ? b[k % 8] : b[7 - (k % 8)];
        if (bits[k] !== e) chk("R7 mosi bit order", {31'd0, bits[k]}, {31'd0, e});
      end
      checks++;
      chk("R11 cs released after done", {31'd0, spi_cs_n}, 32'd1);
      bus_rd(12'h10C, d); chk("R2 rx level", 32'(d[31:24]), 32'(nrx));
      chk("R2 tx level drained", 32'(d[15:8]), 32'd0);
      for (int i = 0; i < nrx; i++) begin
        bus_rd(12'h020, d);
        chk("R8 rx byte", d, 32'((i < ntx) ? vbyte(seed, i) : 8'h00));
      end
      bus_rd(12'h008, d);
      chk("R9 status", d, DONE | ((ntx > 0) ? 32'h2 : 32'h0) | ((nrx > 0) ? 32'h1 : 32'h0));
      bus_wr(12'h008, 32'hFFFF_FFFF);
      bus_rd(12'h008, d); chk("R9 w1c clears", d, 32'h0);
      bus_wr(12'h004, COMMIT);
    end

    // R4 clamp
    bus_wr(12'h030, 32'd0);    bus_rd(12'h030, d); chk("R4 clamp low", d, 32'd2);
    bus_wr(12'h030, 32'd5000); bus_rd(12'h030, d); chk("R4 clamp high", d, 32'd2047);
    bus_wr(12'h030, 32'd777);  bus_rd(12'h030, d); chk("R4 in range", d, 32'd777);
    bus_wr(12'h030, 32'd2);

    // R6 commit bit
    bus_wr(12'h004, PIO | 32'h80);  bus_rd(12'h004, d); chk("R6 write without commit ignored", d, 32'h0);
    bus_wr(12'h004, COMMIT | 32'h80); bus_rd(12'h004, d); chk("R6 committed field", d, 32'h80);
    bus_wr(12'h004, COMMIT);

    // R5 clock gate, R11 cs while armed, R10 interrupt
    bus_wr(12'h000, 32'h0);
    bus_wr(12'h04C, 32'd1);
    bus_wr(12'h034, 32'd1);
    bus_wr(12'h010, 32'hA5);
    edge_n = 0;
    bus_wr(12'h004, COMMIT | PIO | IEDONE);
    repeat (100) @(negedge clk);
    chk("R5 no sclk while gated", 32'(edge_n), 32'd0);
    chk("R11 cs low while armed", {31'd0, spi_cs_n}, 32'd0);
    chk("R10 irq low before done", {31'd0, irq}, 32'd0);
    bus_wr(12'h000, 32'hD);
    wait_done();
    chk("R5 clock runs on 0xD", 32'(edge_n), 32'd8);
    repeat (20) @(negedge clk);
    chk("R10 irq high and held", {31'd0, irq}, 32'd1);
    bus_wr(12'h008, DONE);
    @(negedge clk);
    chk("R10 irq clears with status", {31'd0, irq}, 32'd0);
    bus_rd(12'h020, d); chk("R8 single byte loopback", d, 32'hA5);
    bus_wr(12'h008, 32'hFFFF_FFFF);
    bus_wr(12'h004, COMMIT);

    // R3 empty read
    bus_rd(12'h020, d); chk("R3 empty read zero", d, 32'h0);
    bus_rd(12'h10C, d); chk("R3 level unchanged", 32'(d[31:24]), 32'd0);

    // R2 full queue drops the extra write
    for (int i = 0; i < 17; i++) bus_wr(12'h010, 32'(i));
    bus_rd(12'h10C, d); chk("R2 tx level capped", 32'(d[15:8]), 32'd16);
    bus_wr(12'h04C, 32'd16);
    bus_wr(12'h034, 32'd16);
    bus_wr(12'h004, COMMIT | PIO);
    wait_done();
    for (int i = 0; i < 16; i++) begin
      bus_rd(12'h020, d);
      if (d !== 32'(i)) chk("R2 queued data after drop", d, 32'(i));
    end
    checks++;
    bus_rd(12'h10C, d); chk("R2 queues empty after drain", d, 32'h0);
    bus_wr(12'h008, 32'hFFFF_FFFF);
    bus_wr(12'h004, COMMIT);

    // R12 stalled response
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h030;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 response valid", {31'd0, rsp_valid}, 32'd1);
    chk("R12 ready low while stalled", {31'd0, req_ready}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R12 data held", rsp_rdata, 32'd2);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R12 response taken", {31'd0, rsp_valid}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule